// File: doc/BRIEF.md
# Masked Vectored Interrupt Controller

This block gathers level-sensitive interrupt lines from the peripherals of a processor subsystem. It presents them to the core as a single request wire and an 8-bit vector bus. Each line is sampled into a raw pending vector. That vector is ANDed with a software-owned enable mask, and the result is encoded into a vector number.

The block does no priority arbitration. When exactly one enabled source is active, the vector names that source. When several enabled sources are active at once, the vector takes one shared value, and software then reads the status words to choose the service order.

A small 32-bit register port lets software write the mask and read the mask, raw and masked vectors. A mask write recomputes the outputs in the same way a line change does.

Top module: `irq_vec_ctrl`

## Requirements
- R1: The masked vector equals the raw pending vector ANDed with the mask. A read at offset 0x8 returns it, zero-extended to 32 bits.
- R2: When exactly one masked bit i (0-based) is set, irq_o is 1 and irq_vec_o is 0x31 + i.
- R3: When two or more masked bits are set, irq_o is 1 and irq_vec_o is 0x30.
- R4: When no masked bit is set, irq_o is 0 and irq_vec_o is 0.
- R5: A full-word write at offset 0x0 loads the mask from wdata bits 30:0. The outputs reflect the new mask after the same clock edge that stores it, just as they reflect a line change.
- R6: Raw bit n-1 follows the level of external line n (src_i bit n-1) at every clock edge. A read at offset 0x4 returns the raw vector, zero-extended.
- R7: A read at offset 0x0 returns the mask. Bit 31 always reads 0, and writes to bit 31 have no effect.
- R8: A write to any offset other than 0x0 sets bus_err_o in the cycle after the access and leaves the mask unchanged.
- R9: An access whose byte enables are not all 4'hF is rejected. It sets bus_err_o, returns read data 0 and leaves the mask unchanged.
- R10: A read of an offset other than 0x0, 0x4 or 0x8 returns 0 and sets bus_err_o.
- R11: Reset clears the mask and the raw vector, with irq_o at 0 and irq_vec_o at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 31 | Level interrupt lines; bit n-1 carries line n |
| bus_req_i | input | 1 | Register access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 4 | Byte offset of the register |
| bus_be_i | input | 4 | Byte enables; only 4'hF is accepted |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after the access |
| bus_err_o | output | 1 | Access error, valid the cycle after the access |
| irq_o | output | 1 | Interrupt request to the core |
| irq_vec_o | output | 8 | Vector number to the core |

## Verification
A mask write and a change of the source lines can land in the same clock edge. The outputs must then be encoded from the new lines ANDed with the new mask, with no stale term from either.

The bench provokes this directly. In one cycle it raises two sources while a write enables only one of them, and it expects the single-source vector of the enabled line. Random cycles also mix line changes with concurrent mask writes, and a reference model compares each result.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned BE_W   = DATA_W / 8;

  typedef enum logic [ADDR_W-1:0] {
    OFS_MASK = 4'h0,
    OFS_RAW  = 4'h4,
    OFS_MSKD = 4'h8
  } reg_ofs_e;
endpackage

// File: rtl/irq_vec_regs.sv
module irq_vec_regs
  import irq_vec_pkg::*;
#(
  parameter int unsigned NUM_SRC = 31
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [BE_W-1:0]    be_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [NUM_SRC-1:0] raw_i,
  output logic [NUM_SRC-1:0] mask_o,
  output logic [NUM_SRC-1:0] mask_nxt_o,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               err_o
);
  localparam int unsigned PAD_W = DATA_W - NUM_SRC;

  logic [NUM_SRC-1:0] mask_q;
  logic               full_be, hit_mask, mask_wr, rd_ok;
  logic [DATA_W-1:0]  rdata_d;
  logic               err_d;

  assign full_be  = &be_i;
  assign hit_mask = (addr_i == OFS_MASK);
  assign mask_wr  = req_i & we_i & full_be & hit_mask;
  assign mask_nxt_o = mask_wr ? wdata_i[NUM_SRC-1:0] : mask_q;
  assign mask_o   = mask_q;

  always_comb begin
    rdata_d = '0;
    rd_ok   = 1'b0;
    if (req_i && !we_i && full_be) begin
      unique case (addr_i)
        OFS_MASK: begin rdata_d = {{PAD_W{1'b0}}, mask_q};          rd_ok = 1'b1; end
        OFS_RAW:  begin rdata_d = {{PAD_W{1'b0}}, raw_i};           rd_ok = 1'b1; end
        OFS_MSKD: begin rdata_d = {{PAD_W{1'b0}}, raw_i & mask_q};  rd_ok = 1'b1; end
        default:  begin rdata_d = '0;                               rd_ok = 1'b0; end
      endcase
    end
    err_d = req_i & (!full_be | (we_i ? !hit_mask : !rd_ok));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= '0;
      rdata_o <= '0;
      err_o   <= 1'b0;
    end else begin
      mask_q  <= mask_nxt_o;
      rdata_o <= rdata_d;
      err_o   <= err_d;
    end
  end
endmodule

// File: rtl/irq_vec_enc.sv
module irq_vec_enc #(
  parameter int unsigned NUM_SRC    = 31,
  parameter int unsigned VEC_W      = 8,
  parameter logic [7:0]  VEC_SHARED = 8'h30,
  parameter logic [7:0]  VEC_FIRST  = 8'h31
) (
  input  logic [NUM_SRC-1:0] masked_i,
  output logic               req_o,
  output logic [VEC_W-1:0]   vec_o
);
  localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [IDX_W-1:0] term [NUM_SRC];
  logic [IDX_W-1:0] idx;
  logic             multi;

  // Index terms: only meaningful when a single bit is set
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_term
    assign term[g] = masked_i[g] ? IDX_W'(g) : '0;
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < NUM_SRC; i++) idx = idx | term[i];
  end

  assign multi = |(masked_i & (masked_i - NUM_SRC'(1)));
  assign req_o = |masked_i;

  always_comb begin
    if (!req_o)     vec_o = '0;
    else if (multi) vec_o = VEC_W'(VEC_SHARED);
    else            vec_o = VEC_W'(VEC_FIRST) + VEC_W'(idx);
  end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_vec_pkg::*;
#(
  parameter int unsigned NUM_SRC    = 31,
  parameter int unsigned VEC_W      = 8,
  parameter logic [7:0]  VEC_SHARED = 8'h30,
  parameter logic [7:0]  VEC_FIRST  = 8'h31
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               bus_req_i,
  input  logic               bus_we_i,
  input  logic [3:0]         bus_addr_i,
  input  logic [3:0]         bus_be_i,
  input  logic [31:0]        bus_wdata_i,
  output logic [31:0]        bus_rdata_o,
  output logic               bus_err_o,
  output logic               irq_o,
  output logic [VEC_W-1:0]   irq_vec_o
);
  logic [NUM_SRC-1:0] raw_q, mask_q, mask_nxt, masked_nxt;
  logic               req_d;
  logic [VEC_W-1:0]   vec_d;

  irq_vec_regs #(.NUM_SRC(NUM_SRC)) regs_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (bus_req_i),
    .we_i       (bus_we_i),
    .addr_i     (bus_addr_i),
    .be_i       (bus_be_i),
    .wdata_i    (bus_wdata_i),
    .raw_i      (raw_q),
    .mask_o     (mask_q),
    .mask_nxt_o (mask_nxt),
    .rdata_o    (bus_rdata_o),
    .err_o      (bus_err_o)
  );

  // Encode from next-state values so lines, mask and outputs move together
  assign masked_nxt = src_i & mask_nxt;

  irq_vec_enc #(
    .NUM_SRC(NUM_SRC), .VEC_W(VEC_W),
    .VEC_SHARED(VEC_SHARED), .VEC_FIRST(VEC_FIRST)
  ) enc_i (
    .masked_i (masked_nxt),
    .req_o    (req_d),
    .vec_o    (vec_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q     <= '0;
      irq_o     <= 1'b0;
      irq_vec_o <= '0;
    end else begin
      raw_q     <= src_i;
      irq_o     <= req_d;
      irq_vec_o <= vec_d;
    end
  end
endmodule

// File: rtl/irq_vec_chk.sv
module irq_vec_chk #(
  parameter int unsigned NUM_SRC    = 31,
  parameter int unsigned VEC_W      = 8,
  parameter logic [7:0]  VEC_SHARED = 8'h30,
  parameter logic [7:0]  VEC_FIRST  = 8'h31
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] src_i,
  input logic               bus_req_i,
  input logic               bus_we_i,
  input logic [3:0]         bus_addr_i,
  input logic [3:0]         bus_be_i,
  input logic [31:0]        bus_wdata_i,
  input logic               bus_err_o,
  input logic               irq_o,
  input logic [VEC_W-1:0]   irq_vec_o,
  input logic [NUM_SRC-1:0] raw_q,
  input logic [NUM_SRC-1:0] mask_q
);
  logic [NUM_SRC-1:0] mskd;
  assign mskd = raw_q & mask_q;

  a_r2_single_vec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(mskd) == 1) |-> (irq_o && irq_vec_o >= VEC_W'(VEC_FIRST)
                                 && irq_vec_o < VEC_W'(VEC_FIRST) + VEC_W'(NUM_SRC)));

  a_r3_shared_vec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(mskd) > 1) |-> (irq_o && irq_vec_o == VEC_W'(VEC_SHARED)));

  a_r4_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mskd == '0) |-> (!irq_o && irq_vec_o == '0));

  a_r5_mask_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && bus_we_i && bus_be_i == 4'hF && bus_addr_i == 4'h0)
      |=> (mask_q == $past(bus_wdata_i[NUM_SRC-1:0])));

  a_r6_raw_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (raw_q == $past(src_i)));

  a_r8_bad_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && bus_we_i && bus_addr_i != 4'h0)
      |=> (bus_err_o && $stable(mask_q)));
endmodule

bind irq_vec_ctrl irq_vec_chk #(
  .NUM_SRC(NUM_SRC), .VEC_W(VEC_W),
  .VEC_SHARED(VEC_SHARED), .VEC_FIRST(VEC_FIRST)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .src_i       (src_i),
  .bus_req_i   (bus_req_i),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_be_i    (bus_be_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_err_o   (bus_err_o),
  .irq_o       (irq_o),
  .irq_vec_o   (irq_vec_o),
  .raw_q       (raw_q),
  .mask_q      (mask_q)
);

// File: tb/irq_vec_ctrl_tb_top.sv
module irq_vec_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic [30:0] src;
  logic        req, we;
  logic [3:0]  addr, be;
  logic [31:0] wdata, rdata;
  logic        err, irq;
  logic [7:0]  vec;

  int          n_chk = 0, n_err = 0;
  bit          done = 1'b0;
  logic [30:0] mdl_mask;

  always #2 clk = ~clk;

  irq_vec_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .src_i(src),
    .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr), .bus_be_i(be),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .bus_err_o(err),
    .irq_o(irq), .irq_vec_o(vec)
  );

  function automatic logic [7:0] exp_vec(logic [30:0] m);
    int n = $countones(m);
    if (n == 0) return 8'h00;
    if (n > 1)  return 8'h30;
    for (int i = 0; i < 31; i++) if (m[i]) return 8'h31 + 8'(i);
    return 8'h00;
  endfunction

  function automatic string tag_of(logic [30:0] m);
    int n = $countones(m);
    return (n == 0) ? "R4" : (n == 1) ? "R2" : "R3";
  endfunction

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", r, act, exp);
    end
  endtask

  task automatic chk_out(string r);
    logic [30:0] m = src & mdl_mask;
    chk(r, {31'd0, irq}, {31'd0, (m != 0)});
    chk(r, {24'd0, vec}, {24'd0, exp_vec(m)});
  endtask

  task automatic bus(input logic w, input logic [3:0] a, input logic [3:0] b,
                     input logic [31:0] d, output logic [31:0] rd, output logic e);
    req = 1'b1; we = w; addr = a; be = b; wdata = d;
    if (w && a == 4'h0 && b == 4'hF) mdl_mask = d[30:0];
    @(negedge clk);
    rd = rdata; e = err;
    req = 1'b0; we = 1'b0;
  endtask

  initial begin
    logic [31:0] rd;
    logic        e;
    rst_ni = 1'b0; src = '0; req = 0; we = 0; addr = '0; be = '0; wdata = '0;
    mdl_mask = '0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk("R11", {31'd0, irq}, 32'd0);
    chk("R11", {24'd0, vec}, 32'd0);
    bus(1'b0, 4'h0, 4'hF, '0, rd, e);
    chk("R11", rd, 32'd0);

    // R7 bit 31 dropped
    bus(1'b1, 4'h0, 4'hF, 32'hFFFF_FFFF, rd, e);
    chk("R5", {31'd0, e}, 32'd0);
    bus(1'b0, 4'h0, 4'hF, '0, rd, e);
    chk("R7", rd, 32'h7FFF_FFFF);

    // R2 every single source
    for (int i = 0; i < 31; i++) begin
      src = 31'(1) << i;
      @(negedge clk);
      chk("R2", {24'd0, vec}, 32'h31 + i);
      chk("R2", {31'd0, irq}, 32'd1);
    end

    // R3 multi and R4 none
    src = (31'(1) << 3) | (31'(1) << 17);
    @(negedge clk);
    chk_out("R3");
    src = '0;
    @(negedge clk);
    chk_out("R4");

    // R5 mask cleared and set while source 5 stays active
    src = 31'(1) << 5;
    @(negedge clk);
    chk_out("R2");
    bus(1'b1, 4'h0, 4'hF, 32'd0, rd, e);
    chk("R5", {31'd0, irq}, 32'd0);
    chk("R5", {24'd0, vec}, 32'd0);
    bus(1'b1, 4'h0, 4'hF, 32'd1 << 5, rd, e);
    chk("R5", {31'd0, irq}, 32'd1);
    chk("R5", {24'd0, vec}, 32'h36);

    // R5 line change and mask write on the same edge
    src = (31'(1) << 2) | (31'(1) << 9);
    bus(1'b1, 4'h0, 4'hF, 32'd1 << 9, rd, e);
    chk("R5", {24'd0, vec}, 32'h3A);

    // R6 raw readback, R1 masked readback
    bus(1'b1, 4'h0, 4'hF, 32'h0000_F0F0, rd, e);
    src = 31'h12345;
    @(negedge clk);
    bus(1'b0, 4'h4, 4'hF, '0, rd, e);
    chk("R6", rd, 32'h0001_2345);
    bus(1'b0, 4'h8, 4'hF, '0, rd, e);
    chk("R1", rd, 32'h0001_2345 & 32'h0000_F0F0);
    chk("R1", {31'd0, e}, 32'd0);

    // R8 write to another offset
    bus(1'b1, 4'h4, 4'hF, 32'd0, rd, e);
    chk("R8", {31'd0, e}, 32'd1);
    bus(1'b0, 4'h0, 4'hF, '0, rd, e);
    chk("R8", rd, 32'h0000_F0F0);

    // R9 partial byte enables
    bus(1'b1, 4'h0, 4'h3, 32'd0, rd, e);
    chk("R9", {31'd0, e}, 32'd1);
    bus(1'b0, 4'h0, 4'h1, '0, rd, e);
    chk("R9", rd, 32'd0);
    chk("R9", {31'd0, e}, 32'd1);
    bus(1'b0, 4'h0, 4'hF, '0, rd, e);
    chk("R9", rd, 32'h0000_F0F0);

    // R10 unmapped reads
    bus(1'b0, 4'hC, 4'hF, '0, rd, e);
    chk("R10", rd, 32'd0);
    chk("R10", {31'd0, e}, 32'd1);
    bus(1'b0, 4'h2, 4'hF, '0, rd, e);
    chk("R10", {31'd0, e}, 32'd1);

    // Random lines with concurrent mask writes
    for (int k = 0; k < 400; k++) begin
      logic [31:0] r = $urandom;
      src = 31'($urandom) & (((r[3:0] < 4)) ? 31'(1) << (r[8:4] % 31) : 31'h7FFF_FFFF);
      if (r[10:9] == 2'b00) begin
        bus(1'b1, 4'h0, 4'hF, $urandom, rd, e);
      end else begin
        @(negedge clk);
      end
      chk_out(tag_of(src & mdl_mask));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule